// File: doc/BRIEF.md
# Load Store-Wait Predictor

This block predicts which loads are likely to read memory before an older store to the same address has written it. It holds a table of one-bit "hold" flags indexed by the program counter of a load. When the front end fetches a load, it presents the load's PC and receives that load's flag on the same cycle. The flag then travels with the load into the issue queue. When the ordering-check logic reports that a load read stale data, the load's PC is sent back and its flag is set. A set flag makes the load wait in the issue queue while any older store is still unissued. A load with a clear flag may issue without looking at stores.

The table keeps no store-to-load pairing, so flags build up and would eventually hold loads that no longer need it. A small wipe sequencer therefore clears every flag at a fixed interval. It has two states. In `T_RUN` it counts cycles. On the transition `RUN_TO_WIPE`, taken when the count reaches its last value, it enters `T_WIPE` for exactly one cycle, and every flag is zeroed at the end of that cycle. It then returns to `T_RUN` with the count at zero, through the transition `WIPE_TO_RUN`. The period is one parameter, `CLEAR_INTERVAL`, measured in cycles.

Top module: `stwait_predictor`

## Requirements
- R1: While reset is asserted and right after it is released, every table entry reads 0 at the lookup port.
- R2: The table index is PC bits [IDX_LSB+IDX_W-1 : IDX_LSB] (IDX_LSB = 2 and IDX_W = 10 by default, giving 1024 entries). The other PC bits are ignored, so two PCs that agree on those bits share one entry.
- R3: A violation report (`viol_valid` = 1) sets the entry selected by `viol_pc` at the clock edge. A lookup of that entry returns 1 from the next cycle on.
- R4: The lookup output is combinational from the current table contents. A lookup in the same cycle as a set of the same entry returns the value held before the set.
- R5: Counting cycles from reset release starting at 0, the wipe takes place in every cycle n with n mod CLEAR_INTERVAL = CLEAR_INTERVAL-1. All entries read 0 from the following cycle, and they are unchanged up to and during that cycle.
- R6: When a set and a wipe fall in the same cycle, the wipe wins and the entry reads 0 afterwards.
- R7: With `iq_wait` = 1 and `iq_older_store` = 1, `iq_may_issue` is 0.
- R8: With `iq_wait` = 0, `iq_may_issue` is 1 whatever `iq_older_store` is. With `iq_wait` = 1 and `iq_older_store` = 0 it is also 1.
- R9: A set changes only its own entry, and in a cycle with neither a set nor a wipe no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | PC_W | PC of the load being fetched |
| fetch_wait | output | 1 | Hold flag for `fetch_pc`, valid in the same cycle |
| viol_valid | input | 1 | An ordering violation is being reported this cycle |
| viol_pc | input | PC_W | PC of the load that violated |
| iq_wait | input | 1 | Hold flag carried by the issue-queue candidate |
| iq_older_store | input | 1 | An older store is still unissued |
| iq_may_issue | output | 1 | Candidate load is eligible to issue |

## Verification
Three functions can fall in one cycle. A violation set can coincide with the periodic wipe, and a lookup can coincide with a set of the very entry it reads. The bench keeps its own cycle count from reset release. It waits for the cycle the wipe is due and drives a set into exactly that cycle, then expects the entry to read 0 afterwards. It also drives a set and a lookup of one PC together and expects the old value during that cycle and the new value in the next one.

// File: rtl/sw_pred_pkg.sv
package sw_pred_pkg;
    typedef enum logic [0:0] {
        T_RUN  = 1'b0,
        T_WIPE = 1'b1
    } wipe_state_e;
endpackage

// File: rtl/sw_wipe_timer.sv
module sw_wipe_timer
    import sw_pred_pkg::*;
#(
    parameter int INTERVAL = 16384
) (
    input  logic clk,
    input  logic rst_n,
    output logic wipe
);
    localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 2);

    wipe_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            T_RUN: begin
                if (cnt_q == LAST) begin
                    state_d = T_WIPE;      // RUN_TO_WIPE
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            T_WIPE: begin
                state_d = T_RUN;           // WIPE_TO_RUN
                cnt_d   = '0;
            end
            default: begin
                state_d = T_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            T_WIPE:  wipe = 1'b1;
            default: wipe = 1'b0;
        endcase
    end

    // R5
    run_to_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_RUN && cnt_q == LAST) |=> (state_q == T_WIPE));

    // R5
    wipe_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_WIPE) |=> (state_q == T_RUN && cnt_q == '0 && !wipe));
endmodule

// File: rtl/sw_flag_table.sv
module sw_flag_table #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_flag,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             wipe_en
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (wipe_en) begin
            flags <= '0;
        end else if (set_en) begin
            flags[set_idx] <= 1'b1;
        end
    end

    assign rd_flag = flags[rd_idx];

    // R3
    set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !wipe_en) |=> flags[$past(set_idx)]);

    // R6
    wipe_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_en |=> (flags == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !wipe_en) |=> $stable(flags));
endmodule

// File: rtl/sw_issue_gate.sv
module sw_issue_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_bit,
    input  logic store_pending,
    output logic may_issue
);
    always_comb begin
        may_issue = 1'b1;
        if (wait_bit && store_pending) begin
            may_issue = 1'b0;
        end
    end

    // R7
    flagged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_bit && store_pending) |-> !may_issue);

    // R8
    unflagged_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_bit |-> may_issue);
endmodule

// File: rtl/stwait_predictor.sv
module stwait_predictor #(
    parameter int PC_W           = 32,
    parameter int IDX_W          = 10,
    parameter int IDX_LSB        = 2,
    parameter int CLEAR_INTERVAL = 16384
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            fetch_wait,
    input  logic            viol_valid,
    input  logic [PC_W-1:0] viol_pc,
    input  logic            iq_wait,
    input  logic            iq_older_store,
    output logic            iq_may_issue
);
    logic [IDX_W-1:0] fetch_idx;
    logic [IDX_W-1:0] viol_idx;
    logic             wipe;

    assign fetch_idx = fetch_pc[IDX_LSB +: IDX_W];
    assign viol_idx  = viol_pc[IDX_LSB +: IDX_W];

    sw_wipe_timer #(.INTERVAL(CLEAR_INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .wipe  (wipe)
    );

    sw_flag_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (fetch_idx),
        .rd_flag (fetch_wait),
        .set_en  (viol_valid),
        .set_idx (viol_idx),
        .wipe_en (wipe)
    );

    sw_issue_gate u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .wait_bit      (iq_wait),
        .store_pending (iq_older_store),
        .may_issue     (iq_may_issue)
    );

    // R4
    read_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && !wipe && fetch_idx == viol_idx && !fetch_wait)
        |=> ($past(fetch_pc) != fetch_pc) || fetch_wait);
endmodule

// File: tb/tb_stwait_predictor.sv
`timescale 1ns/1ps
module tb_stwait_predictor;
    localparam int PC_W  = 16;
    localparam int IDX_W = 4;
    localparam int LSB   = 2;
    localparam int INTV  = 64;
    localparam int N     = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            fetch_wait;
    logic            viol_valid = 1'b0;
    logic [PC_W-1:0] viol_pc = '0;
    logic            iq_wait = 1'b0;
    logic            iq_older_store = 1'b0;
    logic            iq_may_issue;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [N-1:0] model = '0;

    always #2 clk = ~clk;

    stwait_predictor #(
        .PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(LSB), .CLEAR_INTERVAL(INTV)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .fetch_pc(fetch_pc), .fetch_wait(fetch_wait),
        .viol_valid(viol_valid), .viol_pc(viol_pc),
        .iq_wait(iq_wait), .iq_older_store(iq_older_store),
        .iq_may_issue(iq_may_issue)
    );

    // reference model of the table and the wipe schedule
    always @(posedge clk) begin
        if (rst_n) begin
            if ((cyc % INTV) == INTV - 1) model = '0;
            else if (viol_valid) model[viol_pc[LSB +: IDX_W]] = 1'b1;
            cyc = cyc + 1;
        end
    end

    task automatic check(input logic got, input logic exp, input string req);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %b expected %b (cyc %0d)", req, got, exp, cyc);
        end
    endtask

    function automatic logic [PC_W-1:0] pc_of(input int idx, input int hi);
        logic [PC_W-1:0] p;
        p = PC_W'(hi) << (LSB + IDX_W);
        p[LSB +: IDX_W] = IDX_W'(idx);
        p[LSB-1:0] = LSB'(hi);
        return p;
    endfunction

    task automatic check_all(input string req);
        for (int i = 0; i < N; i++) begin
            fetch_pc = pc_of(i, i * 7 + 3);
            #0.1;
            check(fetch_wait, model[i], req);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_phase(input int ph);
        while ((cyc % INTV) != ph) step();
    endtask

    initial begin
        #800000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        check_all("R1 after release");

        // R3 / R9: set each entry in turn, verify whole table each step
        for (int i = 0; i < N; i++) begin
            viol_valid = 1'b1;
            viol_pc = pc_of(i, i + 11);
            step();
            viol_valid = 1'b0;
            check_all("R3 R9 set sweep");
        end

        // R5: entries intact up to the wipe cycle, zero after it
        wait_phase(INTV - 2);
        viol_valid = 1'b1; viol_pc = pc_of(5, 1);
        step();
        viol_valid = 1'b0;
        check_all("R5 before wipe");
        check(model[5], 1'b1, "R5 entry set before wipe");
        step();
        check_all("R5 after wipe");
        check(fetch_wait, 1'b0, "R5 cleared");

        // R2: aliasing via ignored PC bits
        viol_valid = 1'b1; viol_pc = pc_of(9, 16'h0abc);
        step();
        viol_valid = 1'b0;
        for (int h = 0; h < 8; h++) begin
            fetch_pc = pc_of(9, h * 37 + 1);
            #0.1;
            check(fetch_wait, 1'b1, "R2 alias same index");
            fetch_pc = pc_of(8, h * 37 + 1);
            #0.1;
            check(fetch_wait, model[8], "R2 neighbour index");
        end

        // R4: set and lookup of the same entry in one cycle
        for (int i = 0; i < N; i += 3) begin
            wait_phase(0);
            viol_valid = 1'b1; viol_pc = pc_of(i, 2);
            fetch_pc = pc_of(i, 5);
            #0.1;
            check(fetch_wait, 1'b0, "R4 old value same cycle");
            step();
            viol_valid = 1'b0;
            #0.1;
            check(fetch_wait, 1'b1, "R4 new value next cycle");
        end

        // R6: set collides with wipe
        for (int k = 0; k < 3; k++) begin
            wait_phase(INTV - 1);
            viol_valid = 1'b1; viol_pc = pc_of(k + 2, 4);
            step();
            viol_valid = 1'b0;
            fetch_pc = pc_of(k + 2, 4);
            #0.1;
            check(fetch_wait, 1'b0, "R6 wipe beats set");
            check_all("R6 table empty");
        end

        // R7 / R8: issue gate, all input combinations
        for (int v = 0; v < 4; v++) begin
            iq_wait = v[1];
            iq_older_store = v[0];
            #0.1;
            check(iq_may_issue, !(v[1] && v[0]),
                  (v[1] && v[0]) ? "R7 hold flagged load" : "R8 load eligible");
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule